// File: doc/BRIEF.md
# Floating Register Block Transfer Sequencer

This block steers a multi-register move between an eight-entry floating point register file and a 32-bit memory port. A single start strobe presents a first register index, a register count, a base address, a byte offset, one of four addressing modes, a writeback request and the identity of the integer register that holds the base. The block validates the request, then issues one beat per 32-bit word, carrying the register index, the word number inside that register and the byte address. Each register travels as three words of a 96-bit internal value, so the bits are copied exactly and no arithmetic exception can arise.

Two of the modes are plain indexed forms: pre-indexed, where the offset is added before the transfer, and post-indexed, where the offset is added after it. The other two are stack disciplines: full-descending and empty-ascending. In the stack modes the size of the block (twelve bytes per register) takes the place of the offset. Decrementing forms first compute the lowest address of the block and then walk upward. At the end the block reports the updated base value and whether it must be written back. A request it cannot carry out produces a one-cycle illegal pulse and no beats.

States: `ST_IDLE` (waiting), `ST_XFER` (issuing beats), `ST_DONE` (one-cycle completion report), `ST_FAULT` (one-cycle rejection report). Transitions: IDLE to XFER on a legal start; IDLE to FAULT on an illegal start; XFER to XFER on a stall or on a non-final accepted beat; XFER to DONE when the final beat is accepted; DONE to IDLE and FAULT to IDLE unconditionally.

Top module: `fp_block_xfer_seq`

## Requirements
- R1: `count` must lie in 1..4. A count of 0 or greater than 4 is illegal.
- R2: Registers move in ascending index order, wrapping from 7 to 0. Each register takes three beats with `word_sel` 0, 1, 2, where word 0 is the least significant 32 bits. Successive beats have byte addresses that rise by 4.
- R3: Pre-indexed mode (`mode`=0): the first address is base+offset. The writeback value is base+offset, and writeback is flagged only when `wb_en` is 1.
- R4: Post-indexed mode (`mode`=1): the first address is the unmodified base. base+offset is always flagged for writeback, whatever `wb_en` is.
- R5: In modes 0 and 1 the offset (12-bit two's complement) must be a multiple of 4 within -1020..+1020, or the request is illegal. In modes 2 and 3 the offset is ignored.
- R6: Full-descending mode (`mode`=2): a store (`is_load`=0) starts at base-12*count and writes back base-12*count. A load starts at base and writes back base+12*count.
- R7: Empty-ascending mode (`mode`=3): a store starts at base and writes back base+12*count. A load starts at base-12*count and writes back base-12*count. In both stack modes writeback is flagged only when `wb_en` is 1.
- R8: A request that would write back while `base_reg` is 15 is illegal. This includes every post-indexed request.
- R9: One word moves per cycle while `mem_ready` is 1. While `mem_ready` is 0 the beat holds its index, word and address.
- R10: `busy` is 1 from the cycle after an accepted start through the completion or rejection cycle. A start while busy is ignored.
- R11: An illegal request raises `illegal` for exactly one cycle, issues no beat and never raises `done`.
- R12: `mem_we` is 1 on store beats and 0 on load beats. A store followed by a load of the same block restores every 96-bit register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| mode | input | 2 | 0 pre-indexed, 1 post-indexed, 2 full-descending, 3 empty-ascending |
| start_idx | input | 3 | First register index |
| count | input | 3 | Number of registers |
| base | input | 32 | Base byte address |
| offset | input | 12 | Signed byte offset (indexed modes) |
| wb_en | input | 1 | Writeback request |
| base_reg | input | 4 | Integer register holding the base |
| mem_ready | input | 1 | Memory accepts the current beat |
| busy | output | 1 | Request in progress |
| beat_valid | output | 1 | A beat is presented |
| mem_we | output | 1 | Beat direction, 1 = store |
| reg_idx | output | 3 | Register index of the beat |
| word_sel | output | 2 | Word within the 96-bit value |
| word_addr | output | 32 | Byte address of the beat |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle rejection pulse |
| wb_valid | output | 1 | Base writeback required (with done) |
| wb_value | output | 32 | Updated base value |

## Verification
The bench targets a transfer starting at register 6 with four registers. An index counter without the wrap would step to register 8 or stall, and the beat checks would report a wrong index. It exercises both stack disciplines for loads and for stores: swapping a pre/post pairing shifts the first address by twelve times the count and corrupts the round-trip data. Offsets of exactly ±1020, 1024, -1024 and 6 probe the boundary of the legality window, and base register 15 is tried with a post-indexed request, where writeback is implicit. A start pulsed in the middle of a stalled transfer must leave the beat sequence untouched. A design that re-latched its inputs would jump to the new index.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    typedef enum logic [1:0] {
        XM_PRE  = 2'd0,
        XM_POST = 2'd1,
        XM_FD   = 2'd2,
        XM_EA   = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_XFER  = 2'd1,
        ST_DONE  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;

endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
    import fpx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 3,
    parameter int OFF_W     = 12,
    parameter int MAX_CNT   = 4,
    parameter int WORDS     = 3,
    parameter int OFF_LIMIT = 1020,
    parameter int PC_REG    = 15
) (
    input  logic              is_load,
    input  logic [1:0]        mode,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              wb_en,
    input  logic [3:0]        base_reg,
    output logic              legal,
    output logic [ADDR_W-1:0] first_addr,
    output logic              wb_do,
    output logic [ADDR_W-1:0] wb_addr
);

    localparam int REG_BYTES = WORDS * 4;
    localparam logic signed [OFF_W-1:0] OFF_MAX = OFF_W'(OFF_LIMIT);

    xfer_mode_e        xm;
    logic [ADDR_W-1:0] blk_bytes;
    logic [ADDR_W-1:0] off_ext;
    logic [ADDR_W-1:0] above;
    logic [ADDR_W-1:0] below;
    logic [ADDR_W-1:0] shifted;
    logic              cnt_ok;
    logic              off_ok;
    logic              off_used;

    assign xm        = xfer_mode_e'(mode);
    assign blk_bytes = ADDR_W'(count) * ADDR_W'(REG_BYTES);
    assign off_ext   = {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
    assign above     = base + blk_bytes;
    assign below     = base - blk_bytes;
    assign shifted   = base + off_ext;

    assign cnt_ok = (count != '0) && (int'(count) <= MAX_CNT);
    assign off_ok = (offset[1:0] == 2'b00)
                 && ($signed(offset) <= OFF_MAX)
                 && ($signed(offset) >= -OFF_MAX);

    always_comb begin
        first_addr = base;
        wb_addr    = base;
        wb_do      = wb_en;
        off_used   = 1'b0;
        unique case (xm)
            XM_PRE: begin
                first_addr = shifted;
                wb_addr    = shifted;
                off_used   = 1'b1;
            end
            XM_POST: begin
                wb_addr  = shifted;
                wb_do    = 1'b1;
                off_used = 1'b1;
            end
            XM_FD: begin
                if (is_load) begin
                    wb_addr = above;
                end else begin
                    first_addr = below;
                    wb_addr    = below;
                end
            end
            XM_EA: begin
                if (is_load) begin
                    first_addr = below;
                    wb_addr    = below;
                end else begin
                    wb_addr = above;
                end
            end
            default: ;
        endcase
    end

    assign legal = cnt_ok
                && (!off_used || off_ok)
                && !(wb_do && (base_reg == 4'(PC_REG)));

endmodule

// File: rtl/fpx_walker.sv
module fpx_walker #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 3,
    parameter int NREG   = 8,
    parameter int WORDS  = 3,
    parameter int MAX_CNT = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       load_en,
    input  logic                       step_en,
    input  logic [ADDR_W-1:0]          first_addr,
    input  logic [$clog2(NREG)-1:0]    first_idx,
    input  logic [CNT_W-1:0]           count,
    input  logic                       is_load,
    input  logic                       wb_do,
    input  logic [ADDR_W-1:0]          wb_addr,
    output logic [ADDR_W-1:0]          addr_q,
    output logic [$clog2(NREG)-1:0]    idx_q,
    output logic [$clog2(WORDS)-1:0]   word_q,
    output logic                       last_beat,
    output logic                       store_q,
    output logic                       wb_do_q,
    output logic [ADDR_W-1:0]          wb_addr_q
);

    localparam int IDX_W  = $clog2(NREG);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BEAT_W = $clog2(MAX_CNT * WORDS + 1);

    logic [BEAT_W-1:0] left_q;
    logic [IDX_W-1:0]  idx_nxt;

    assign last_beat = (left_q == BEAT_W'(1));

    generate
        if ((NREG & (NREG - 1)) == 0) begin : g_pow2_wrap
            assign idx_nxt = idx_q + IDX_W'(1);
        end else begin : g_cmp_wrap
            assign idx_nxt = (idx_q == IDX_W'(NREG - 1)) ? '0 : idx_q + IDX_W'(1);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q    <= '0;
            idx_q     <= '0;
            word_q    <= '0;
            left_q    <= '0;
            store_q   <= 1'b0;
            wb_do_q   <= 1'b0;
            wb_addr_q <= '0;
        end else if (load_en) begin
            addr_q    <= first_addr;
            idx_q     <= first_idx;
            word_q    <= '0;
            left_q    <= BEAT_W'(count) * BEAT_W'(WORDS);
            store_q   <= !is_load;
            wb_do_q   <= wb_do;
            wb_addr_q <= wb_addr;
        end else if (step_en) begin
            addr_q <= addr_q + ADDR_W'(4);
            left_q <= left_q - BEAT_W'(1);
            if (word_q == WSEL_W'(WORDS - 1)) begin
                word_q <= '0;
                idx_q  <= idx_nxt;
            end else begin
                word_q <= word_q + WSEL_W'(1);
            end
        end
    end

endmodule

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
    import fpx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic legal,
    input  logic last_beat,
    input  logic mem_ready,
    output logic load_en,
    output logic step_en,
    output logic busy,
    output logic beat_valid,
    output logic done,
    output logic illegal
);

    seq_state_e state_q;
    seq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = legal ? ST_XFER : ST_FAULT;
                end
            end
            ST_XFER: begin
                if (mem_ready && last_beat) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        load_en    = 1'b0;
        step_en    = 1'b0;
        busy       = 1'b1;
        beat_valid = 1'b0;
        done       = 1'b0;
        illegal    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy    = 1'b0;
                load_en = start && legal;
            end
            ST_XFER: begin
                beat_valid = 1'b1;
                step_en    = mem_ready;
            end
            ST_DONE:  done    = 1'b1;
            ST_FAULT: illegal = 1'b1;
            default:  busy    = 1'b0;
        endcase
    end

endmodule

// File: rtl/fp_block_xfer_seq.sv
module fp_block_xfer_seq
    import fpx_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NREG      = 8,
    parameter int WORDS     = 3,
    parameter int MAX_CNT   = 4,
    parameter int OFF_W     = 12,
    parameter int OFF_LIMIT = 1020,
    parameter int PC_REG    = 15,
    localparam int IDX_W    = $clog2(NREG),
    localparam int CNT_W    = 3,
    localparam int WSEL_W   = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_load,
    input  logic [1:0]        mode,
    input  logic [IDX_W-1:0]  start_idx,
    input  logic [CNT_W-1:0]  count,
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    input  logic              wb_en,
    input  logic [3:0]        base_reg,
    input  logic              mem_ready,
    output logic              busy,
    output logic              beat_valid,
    output logic              mem_we,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [WSEL_W-1:0] word_sel,
    output logic [ADDR_W-1:0] word_addr,
    output logic              done,
    output logic              illegal,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_value
);

    logic              legal;
    logic [ADDR_W-1:0] first_addr;
    logic              wb_do;
    logic [ADDR_W-1:0] wb_addr;
    logic              load_en;
    logic              step_en;
    logic              last_beat;
    logic              store_q;
    logic              wb_do_q;

    fpx_decode #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W), .MAX_CNT(MAX_CNT),
        .WORDS(WORDS), .OFF_LIMIT(OFF_LIMIT), .PC_REG(PC_REG)
    ) i_decode (
        .is_load(is_load), .mode(mode), .count(count), .base(base),
        .offset(offset), .wb_en(wb_en), .base_reg(base_reg),
        .legal(legal), .first_addr(first_addr), .wb_do(wb_do), .wb_addr(wb_addr)
    );

    fpx_walker #(
        .ADDR_W(ADDR_W), .CNT_W(CNT_W), .NREG(NREG), .WORDS(WORDS), .MAX_CNT(MAX_CNT)
    ) i_walker (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .step_en(step_en),
        .first_addr(first_addr), .first_idx(start_idx), .count(count),
        .is_load(is_load), .wb_do(wb_do), .wb_addr(wb_addr),
        .addr_q(word_addr), .idx_q(reg_idx), .word_q(word_sel),
        .last_beat(last_beat), .store_q(store_q), .wb_do_q(wb_do_q),
        .wb_addr_q(wb_value)
    );

    fpx_ctrl i_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .legal(legal),
        .last_beat(last_beat), .mem_ready(mem_ready),
        .load_en(load_en), .step_en(step_en), .busy(busy),
        .beat_valid(beat_valid), .done(done), .illegal(illegal)
    );

    assign mem_we   = beat_valid && store_q;
    assign wb_valid = done && wb_do_q;

endmodule

// File: rtl/fpx_checker.sv
module fpx_checker #(
    parameter int ADDR_W = 32,
    parameter int NREG   = 8,
    parameter int WORDS  = 3,
    localparam int IDX_W = $clog2(NREG),
    localparam int WSEL_W = $clog2(WORDS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              beat_valid,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] word_addr,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [WSEL_W-1:0] word_sel,
    input logic              done,
    input logic              illegal,
    input logic              wb_valid
);

    a_r2_word_range: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid |-> (int'(word_sel) < WORDS));

    a_r2_idx_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && mem_ready && (word_sel == WSEL_W'(WORDS - 1)))
        |=> (!beat_valid || (reg_idx == IDX_W'((int'($past(reg_idx)) + 1) % NREG))));

    a_r9_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && mem_ready) |=> (!beat_valid || (word_addr == $past(word_addr) + ADDR_W'(4))));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !mem_ready)
        |=> (beat_valid && $stable(word_addr) && $stable(reg_idx) && $stable(word_sel)));

    a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r10_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!beat_valid && !done && !wb_valid));

    a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |=> !illegal);

    a_r11_one_report: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, illegal, beat_valid}));

endmodule

bind fp_block_xfer_seq fpx_checker #(
    .ADDR_W(ADDR_W), .NREG(NREG), .WORDS(WORDS)
) i_fpx_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy),
    .beat_valid(beat_valid), .mem_ready(mem_ready), .word_addr(word_addr),
    .reg_idx(reg_idx), .word_sel(word_sel), .done(done), .illegal(illegal),
    .wb_valid(wb_valid)
);

// File: tb/test_fp_block_xfer_seq.sv
module test_fp_block_xfer_seq;

    typedef struct packed {
        logic        ld;
        logic [1:0]  md;
        logic [2:0]  sidx;
        logic [2:0]  cnt;
        logic [31:0] bas;
        logic [11:0] off;
        logic        wb;
        logic [3:0]  breg;
        logic        e_ill;
        logic [31:0] e_start;
        logic        e_wb;
        logic [31:0] e_wbv;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 3'd0, 3'd1, 32'h100, 12'h008, 1'b1, 4'd3,  1'b0, 32'h108, 1'b1, 32'h108}, // R3 pre + wb
        '{1'b0, 2'd1, 3'd2, 3'd2, 32'h200, 12'hFF0, 1'b0, 4'd4,  1'b0, 32'h200, 1'b1, 32'h1F0}, // R4 post auto wb
        '{1'b0, 2'd2, 3'd6, 3'd4, 32'h300, 12'h006, 1'b1, 4'd13, 1'b0, 32'h2D0, 1'b1, 32'h2D0}, // R6 FD store, R5 offset ignored
        '{1'b1, 2'd2, 3'd6, 3'd4, 32'h2D0, 12'h000, 1'b1, 4'd13, 1'b0, 32'h2D0, 1'b1, 32'h300}, // R6 FD load
        '{1'b0, 2'd3, 3'd1, 3'd3, 32'h100, 12'h000, 1'b0, 4'd2,  1'b0, 32'h100, 1'b0, 32'h0},   // R7 EA store no wb
        '{1'b1, 2'd3, 3'd1, 3'd3, 32'h124, 12'h000, 1'b1, 4'd2,  1'b0, 32'h100, 1'b1, 32'h100}, // R7 EA load
        '{1'b1, 2'd0, 3'd4, 3'd1, 32'h000, 12'h3FC, 1'b0, 4'd1,  1'b0, 32'h3FC, 1'b0, 32'h0},   // R5 +1020 legal, R3 no wb
        '{1'b1, 2'd0, 3'd0, 3'd2, 32'h400, 12'hC04, 1'b1, 4'd15, 1'b1, 32'h0,   1'b0, 32'h0},   // R8 pc wb
        '{1'b1, 2'd0, 3'd0, 3'd1, 32'h000, 12'h400, 1'b0, 4'd1,  1'b1, 32'h0,   1'b0, 32'h0},   // R5 1024
        '{1'b1, 2'd0, 3'd0, 3'd1, 32'h000, 12'h006, 1'b0, 4'd1,  1'b1, 32'h0,   1'b0, 32'h0},   // R5 misaligned
        '{1'b0, 2'd0, 3'd0, 3'd0, 32'h100, 12'h000, 1'b0, 4'd1,  1'b1, 32'h0,   1'b0, 32'h0},   // R1 zero
        '{1'b0, 2'd0, 3'd0, 3'd5, 32'h100, 12'h000, 1'b0, 4'd1,  1'b1, 32'h0,   1'b0, 32'h0},   // R1 five
        '{1'b0, 2'd1, 3'd0, 3'd1, 32'h100, 12'h004, 1'b0, 4'd15, 1'b1, 32'h0,   1'b0, 32'h0},   // R8 post implies wb
        '{1'b0, 2'd2, 3'd3, 3'd1, 32'h300, 12'h000, 1'b0, 4'd15, 1'b0, 32'h2F4, 1'b0, 32'h0},   // R8 no wb is fine
        '{1'b1, 2'd0, 3'd7, 3'd2, 32'h400, 12'hC04, 1'b1, 4'd5,  1'b0, 32'h004, 1'b1, 32'h004}, // R5 -1020 legal
        '{1'b1, 2'd1, 3'd0, 3'd1, 32'h400, 12'hC00, 1'b0, 4'd5,  1'b1, 32'h0,   1'b0, 32'h0}    // R5 -1024
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        is_load = 1'b0;
    logic [1:0]  mode = '0;
    logic [2:0]  start_idx = '0;
    logic [2:0]  count = '0;
    logic [31:0] base = '0;
    logic [11:0] offset = '0;
    logic        wb_en = 1'b0;
    logic [3:0]  base_reg = '0;
    logic        mem_ready = 1'b0;
    logic        busy, beat_valid, mem_we, done, illegal, wb_valid;
    logic [2:0]  reg_idx;
    logic [1:0]  word_sel;
    logic [31:0] word_addr, wb_value;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int stall_ctr = 0;
    bit finished = 1'b0;

    logic [95:0] rf [8];
    logic [31:0] mem [1024];

    always #2.5 clk = ~clk;

    fp_block_xfer_seq i_fp_block_xfer_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load), .mode(mode),
        .start_idx(start_idx), .count(count), .base(base), .offset(offset),
        .wb_en(wb_en), .base_reg(base_reg), .mem_ready(mem_ready),
        .busy(busy), .beat_valid(beat_valid), .mem_we(mem_we), .reg_idx(reg_idx),
        .word_sel(word_sel), .word_addr(word_addr), .done(done), .illegal(illegal),
        .wb_valid(wb_valid), .wb_value(wb_value)
    );

    // memory and register-file model
    always @(posedge clk) begin
        if (beat_valid && mem_ready) begin
            if (mem_we) mem[word_addr[11:2]] <= rf[reg_idx][32*word_sel +: 32];
            else        rf[reg_idx][32*word_sel +: 32] <= mem[word_addr[11:2]];
        end
    end

    function automatic logic [95:0] pat(input int r);
        return {32'hC000_0000 | r, 32'hB000_0000 | r, 32'hA000_0000 | r};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
            summary();
        end
    end

    task automatic run_vec(input vec_t v, input bit poke);
        int beats;
        int k;
        logic [31:0] exp_addr;
        @(negedge clk);
        is_load = v.ld; mode = v.md; start_idx = v.sidx; count = v.cnt;
        base = v.bas; offset = v.off; wb_en = v.wb; base_reg = v.breg;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (v.e_ill) begin
            chk(illegal === 1'b1, "R11 illegal pulse", 96'(illegal), 96'(1));
            chk(beat_valid === 1'b0 && done === 1'b0, "R11 no beat/done", 96'({beat_valid, done}), 96'(0));
            chk(busy === 1'b1, "R10 busy on reject", 96'(busy), 96'(1));
            @(negedge clk);
            chk(illegal === 1'b0 && busy === 1'b0, "R11 single cycle", 96'({illegal, busy}), 96'(0));
            return;
        end
        beats = 3 * int'(v.cnt);
        k = 0;
        while (k < beats) begin
            mem_ready = (stall_ctr % 3) != 2;
            stall_ctr++;
            if (poke) begin
                start = (k == 1);
                start_idx = 3'd5; base = 32'h777; count = 3'd2;
            end
            exp_addr = v.e_start + 32'(4 * k);
            chk(beat_valid === 1'b1 && busy === 1'b1, "R10 busy/beat", 96'({beat_valid, busy}), 96'(3));
            chk(word_addr === exp_addr, "R2 word address", 96'(word_addr), 96'(exp_addr));
            chk(reg_idx === 3'((int'(v.sidx) + k / 3) % 8), "R2 register order", 96'(reg_idx),
                96'((int'(v.sidx) + k / 3) % 8));
            chk(word_sel === 2'(k % 3), "R2 word select", 96'(word_sel), 96'(k % 3));
            chk(mem_we === !v.ld, "R12 direction", 96'(mem_we), 96'(!v.ld));
            if (mem_ready) k++;
            @(negedge clk);
        end
        mem_ready = 1'b0;
        start = 1'b0;
        chk(done === 1'b1 && busy === 1'b1, "R10 done cycle", 96'({done, busy}), 96'(3));
        chk(wb_valid === v.e_wb, "R3/R4/R6/R7 writeback flag", 96'(wb_valid), 96'(v.e_wb));
        if (v.e_wb) chk(wb_value === v.e_wbv, "R6/R7 writeback value", 96'(wb_value), 96'(v.e_wbv));
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R10 idle after done", 96'({busy, done}), 96'(0));
    endtask

    initial begin
        for (int r = 0; r < 8; r++) rf[r] = pat(r);
        for (int a = 0; a < 1024; a++) mem[a] = '0;
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && beat_valid === 1'b0 && done === 1'b0 && illegal === 1'b0,
            "reset state", 96'({busy, beat_valid, done, illegal}), 96'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0 && wb_valid === 1'b0, "reset idle", 96'({busy, wb_valid}), 96'(0));

        for (int i = 0; i < NV; i++) begin
            if (i == 3) begin
                rf[6] = '0; rf[7] = '0; rf[0] = '0; rf[1] = '0;
            end
            if (i == 5) begin
                rf[1] = '0; rf[2] = '0; rf[3] = '0;
            end
            run_vec(VECS[i], 1'b0);
            if (i == 3) begin
                chk(rf[6] === pat(6) && rf[7] === pat(7), "R12 round trip wrap", rf[6], pat(6));
                chk(rf[0] === pat(0) && rf[1] === pat(1), "R12 round trip low", rf[0], pat(0));
            end
            if (i == 5) begin
                chk(rf[1] === pat(1) && rf[2] === pat(2) && rf[3] === pat(3),
                    "R12 round trip EA", rf[2], pat(2));
            end
        end

        // R10: start pulsed mid-transfer is ignored; R9 stalls interleaved
        run_vec(VECS[2], 1'b1);
        run_vec(VECS[3], 1'b1);
        chk(rf[6] === pat(6), "R10 ignored start keeps data", rf[6], pat(6));

        summary();
    end

endmodule